// File: doc/BRIEF.md
# Memory Retention Pattern Tester

This block runs one retention test on a region of a simple synchronous memory. Software programs a base address, the region size, a start offset, a word pattern, a hold interval and a read gap, then writes a start command. The block fills every word of the region with the pattern and then waits for the hold interval. If enabled, it asserts a refresh-inhibit output for that wait, so that cells which lose charge early show their loss. It then reads the region back, one word at a time, and compares each word with the value written.

The walk through the region starts at the programmed offset and wraps at the end of the region. The fill and the check use the same order. The read pace can be slowed by a programmable number of idle cycles between reads. The first failing address and its data are latched, and a saturating counter holds the number of mismatches. Once a weak location is known, a single-location mode runs the whole test on that one word only, so it can be repeated quickly with other patterns or hold times.

Top module: `mem_retention_tester`

## Requirements
- R1: After reset the phase is IDLE (status register 8, bits 2:0: IDLE=0, FILL=1, HOLD=2, CHECK=3, DONE=4), mem_req and refresh_inhibit are low, and the mismatch count, fail flag (status bit 3), first fail address and data all read zero.
- R2: The written and expected word is selected by control bits 5:4. 0 gives alternating bits with bit 0 set (0x55 for 8 bits), 1 gives its inverse (0xAA), 2 gives the user pattern, and 3 gives the user pattern XOR the zero-extended physical address.
- R3: The fill writes every word of the region exactly once before any read. Write i goes to base + ((s + i) mod (last+1)), taken modulo 2^AW, where last is the region-size register (size minus one) and s is the effective start offset.
- R4: The effective start offset is the programmed offset, or 0 when that offset exceeds last. The check visits the same addresses in the same order as the fill.
- R5: The first read request comes HOLD+2 cycles after the last fill write.
- R6: With inhibit enabled (control bit 2), refresh_inhibit is low during every fill write and high during every check read, and it drops on entry to DONE. With inhibit disabled it never rises.
- R7: With a memory that answers one cycle after a read request, successive read requests are GAP+2 cycles apart.
- R8: Each returned word is compared with its expected value, and every mismatch adds one to the count. The count stops at 2^EW-1 and does not wrap.
- R9: The address and data of the first mismatch of a run are latched, and the fail flag is set. Later mismatches in the same run do not change them.
- R10: With single mode (control bit 3), the run writes and reads only address base + s, once each.
- R11: A start command (control bit 0) has no effect while the phase is FILL, HOLD or CHECK.
- R12: An abort (control bit 1) returns the block to IDLE in the next cycle, with refresh_inhibit low and no further memory requests.
- R13: A run ends in DONE after the last comparison. A new start from DONE clears the count, the fail flag and the latched failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 4 | Register index: 0 control, 1 base, 2 last offset, 3 start offset, 4 pattern, 5 hold, 6 gap, 8 status, 9 first fail address, 10 first fail data, 11 mismatch count |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr, combinational |
| mem_req | output | 1 | Memory access request, one word per cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read data returned |
| refresh_inhibit | output | 1 | Asks the memory controller to stop refreshing |

## Verification
The last comparison of a pass can find a mismatch in the same cycle as the block moves to DONE and drops refresh_inhibit. Counting, first-fail latching and the phase change all act at one edge. To provoke this, the bench corrupts the final word of the walk order (the word just before the start offset) together with an earlier word while the hold interval runs. It then expects a count of two, the earlier word as the first failure, a released inhibit, and the DONE phase. Start commands that land during the hold, and saturation when every word is corrupted, are checked in the same arithmetic way.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_FILL  = 3'd1,
      PH_HOLD  = 3'd2,
      PH_CHECK = 3'd3,
      PH_DONE  = 3'd4
   } phase_e;

   typedef enum logic [1:0] {
      CK_ISSUE = 2'd0,
      CK_WAIT  = 2'd1,
      CK_GAP   = 2'd2
   } ck_e;

   localparam logic [3:0] REG_CTRL   = 4'd0;
   localparam logic [3:0] REG_BASE   = 4'd1;
   localparam logic [3:0] REG_LAST   = 4'd2;
   localparam logic [3:0] REG_OFS    = 4'd3;
   localparam logic [3:0] REG_PAT    = 4'd4;
   localparam logic [3:0] REG_HOLD   = 4'd5;
   localparam logic [3:0] REG_GAP    = 4'd6;
   localparam logic [3:0] REG_STAT   = 4'd8;
   localparam logic [3:0] REG_FADDR  = 4'd9;
   localparam logic [3:0] REG_FDATA  = 4'd10;
   localparam logic [3:0] REG_ECNT   = 4'd11;
endpackage

// File: rtl/rtr_pattern.sv
module rtr_pattern #(
   parameter int DW = 32,
   parameter int AW = 16
) (
   input  logic [1:0]    mode,
   input  logic [DW-1:0] user_pat,
   input  logic [AW-1:0] addr,
   output logic [DW-1:0] word
);
   logic [DW-1:0] alt;
   logic [DW-1:0] amix;

   for (genvar i = 0; i < DW; i++) begin : g_alt
      assign alt[i] = ((i % 2) == 0) ? 1'b1 : 1'b0;
   end

   if (AW >= DW) begin : g_addr_trunc
      assign amix = addr[DW-1:0];
   end else begin : g_addr_ext
      assign amix = {{(DW-AW){1'b0}}, addr};
   end

   always_comb begin
      unique case (mode)
         2'd0:    word = alt;
         2'd1:    word = ~alt;
         2'd2:    word = user_pat;
         default: word = user_pat ^ amix;
      endcase
   end
endmodule

// File: rtl/rtr_walker.sv
module rtr_walker #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [AW-1:0] last,
   input  logic [AW-1:0] ofs,
   input  logic          single,
   output logic [AW-1:0] off,
   output logic          final_step
);
   logic [AW-1:0] cnt_q;
   logic [AW-1:0] off_q;
   logic [AW-1:0] start_eff;
   logic [AW-1:0] last_eff;

   assign start_eff  = (ofs > last) ? '0 : ofs;
   assign last_eff   = single ? '0 : last;
   assign final_step = (cnt_q == last_eff);
   assign off        = off_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         off_q <= '0;
      end else if (load) begin
         cnt_q <= '0;
         off_q <= start_eff;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
         off_q <= (off_q == last) ? '0 : off_q + 1'b1;
      end
   end
endmodule

// File: rtl/rtr_errlog.sv
module rtr_errlog #(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int EW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          cmp_valid,
   input  logic [DW-1:0] got,
   input  logic [DW-1:0] expect_word,
   input  logic [AW-1:0] addr,
   output logic [EW-1:0] err_count,
   output logic          fail_seen,
   output logic [AW-1:0] fail_addr,
   output logic [DW-1:0] fail_data
);
   localparam logic [EW-1:0] CMAX = '1;
   logic mismatch;

   assign mismatch = cmp_valid && (got != expect_word);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         err_count <= '0;
         fail_seen <= 1'b0;
         fail_addr <= '0;
         fail_data <= '0;
      end else if (mismatch) begin
         if (err_count != CMAX) err_count <= err_count + 1'b1;
         if (!fail_seen) begin
            fail_seen <= 1'b1;
            fail_addr <= addr;
            fail_data <= got;
         end
      end
   end
endmodule

// File: rtl/rtr_csr.sv
module rtr_csr
   import rtr_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int EW = 16,
   parameter int HW = 16,
   parameter int GW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          csr_wr,
   input  logic [3:0]    csr_addr,
   input  logic [31:0]   csr_wdata,
   output logic [31:0]   csr_rdata,
   output logic          start_p,
   output logic          abort_p,
   output logic          inh_en,
   output logic          single,
   output logic [1:0]    pmode,
   output logic [AW-1:0] base,
   output logic [AW-1:0] last,
   output logic [AW-1:0] ofs,
   output logic [DW-1:0] user_pat,
   output logic [HW-1:0] hold,
   output logic [GW-1:0] gap,
   input  logic [2:0]    phase,
   input  logic          fail_seen,
   input  logic [AW-1:0] fail_addr,
   input  logic [DW-1:0] fail_data,
   input  logic [EW-1:0] err_count
);
   logic ctrl_wr;
   assign ctrl_wr = csr_wr && (csr_addr == REG_CTRL);
   assign start_p = ctrl_wr && csr_wdata[0];
   assign abort_p = ctrl_wr && csr_wdata[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inh_en   <= 1'b0;
         single   <= 1'b0;
         pmode    <= 2'd0;
         base     <= '0;
         last     <= '0;
         ofs      <= '0;
         user_pat <= '0;
         hold     <= '0;
         gap      <= '0;
      end else if (csr_wr) begin
         unique case (csr_addr)
            REG_CTRL: begin
               inh_en <= csr_wdata[2];
               single <= csr_wdata[3];
               pmode  <= csr_wdata[5:4];
            end
            REG_BASE: base     <= csr_wdata[AW-1:0];
            REG_LAST: last     <= csr_wdata[AW-1:0];
            REG_OFS:  ofs      <= csr_wdata[AW-1:0];
            REG_PAT:  user_pat <= csr_wdata[DW-1:0];
            REG_HOLD: hold     <= csr_wdata[HW-1:0];
            REG_GAP:  gap      <= csr_wdata[GW-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (csr_addr)
         REG_CTRL:  csr_rdata = 32'({pmode, single, inh_en, 2'b00});
         REG_BASE:  csr_rdata = 32'(base);
         REG_LAST:  csr_rdata = 32'(last);
         REG_OFS:   csr_rdata = 32'(ofs);
         REG_PAT:   csr_rdata = 32'(user_pat);
         REG_HOLD:  csr_rdata = 32'(hold);
         REG_GAP:   csr_rdata = 32'(gap);
         REG_STAT:  csr_rdata = 32'({fail_seen, phase});
         REG_FADDR: csr_rdata = 32'(fail_addr);
         REG_FDATA: csr_rdata = 32'(fail_data);
         REG_ECNT:  csr_rdata = 32'(err_count);
         default:   csr_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mem_retention_tester.sv
module mem_retention_tester
   import rtr_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int EW = 16,
   parameter int HW = 16,
   parameter int GW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          csr_wr,
   input  logic [3:0]    csr_addr,
   input  logic [31:0]   csr_wdata,
   output logic [31:0]   csr_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_rvalid,
   output logic          refresh_inhibit
);
   if (AW < 1 || AW > 32) begin : g_bad_aw
      $error("AW must lie in 1..32");
   end
   if (DW < 2 || DW > 32) begin : g_bad_dw
      $error("DW must lie in 2..32");
   end
   if (EW < 1 || EW > 32 || HW < 1 || HW > 32 || GW < 1 || GW > 32) begin : g_bad_cnt
      $error("counter widths must lie in 1..32");
   end

   phase_e        phase_q;
   ck_e           ck_q;
   logic [HW-1:0] hold_cnt;
   logic [GW-1:0] gap_cnt;
   logic          inhibit_q;

   logic          start_p, abort_p, inh_en, single;
   logic [1:0]    pmode;
   logic [AW-1:0] base, last, ofs, off;
   logic [DW-1:0] user_pat, exp_word;
   logic [HW-1:0] hold;
   logic [GW-1:0] gap;
   logic          final_step, start_ok, wk_load, wk_step, cmp_valid, rd_back;
   logic [EW-1:0] err_count;
   logic          fail_seen;
   logic [AW-1:0] fail_addr;
   logic [DW-1:0] fail_data;

   rtr_csr #(.AW(AW), .DW(DW), .EW(EW), .HW(HW), .GW(GW)) u_csr (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .start_p(start_p), .abort_p(abort_p), .inh_en(inh_en), .single(single),
      .pmode(pmode), .base(base), .last(last), .ofs(ofs), .user_pat(user_pat),
      .hold(hold), .gap(gap), .phase(phase_q), .fail_seen(fail_seen),
      .fail_addr(fail_addr), .fail_data(fail_data), .err_count(err_count)
   );

   assign mem_addr  = base + off;
   assign mem_req   = (phase_q == PH_FILL) || (phase_q == PH_CHECK && ck_q == CK_ISSUE);
   assign mem_we    = (phase_q == PH_FILL);
   assign mem_wdata = exp_word;
   assign refresh_inhibit = inhibit_q;

   rtr_pattern #(.DW(DW), .AW(AW)) u_pat (
      .mode(pmode), .user_pat(user_pat), .addr(mem_addr), .word(exp_word)
   );

   assign start_ok  = start_p && !abort_p && (phase_q == PH_IDLE || phase_q == PH_DONE);
   assign rd_back   = (phase_q == PH_CHECK) && (ck_q == CK_WAIT) && mem_rvalid && !abort_p;
   assign cmp_valid = rd_back;
   assign wk_load   = start_ok || (phase_q == PH_FILL && final_step);
   assign wk_step   = (phase_q == PH_FILL && !final_step) || (rd_back && !final_step);

   rtr_walker #(.AW(AW)) u_walk (
      .clk(clk), .rst_n(rst_n), .load(wk_load), .step(wk_step), .last(last),
      .ofs(ofs), .single(single), .off(off), .final_step(final_step)
   );

   rtr_errlog #(.AW(AW), .DW(DW), .EW(EW)) u_log (
      .clk(clk), .rst_n(rst_n), .clear(start_ok), .cmp_valid(cmp_valid),
      .got(mem_rdata), .expect_word(exp_word), .addr(mem_addr),
      .err_count(err_count), .fail_seen(fail_seen), .fail_addr(fail_addr),
      .fail_data(fail_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         ck_q      <= CK_ISSUE;
         hold_cnt  <= '0;
         gap_cnt   <= '0;
         inhibit_q <= 1'b0;
      end else if (abort_p) begin
         phase_q   <= PH_IDLE;
         ck_q      <= CK_ISSUE;
         inhibit_q <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE, PH_DONE: begin
               if (start_ok) phase_q <= PH_FILL;
            end
            PH_FILL: begin
               if (final_step) begin
                  phase_q   <= PH_HOLD;
                  hold_cnt  <= hold;
                  inhibit_q <= inh_en;
               end
            end
            PH_HOLD: begin
               if (hold_cnt == '0) begin
                  phase_q <= PH_CHECK;
                  ck_q    <= CK_ISSUE;
               end else begin
                  hold_cnt <= hold_cnt - 1'b1;
               end
            end
            PH_CHECK: begin
               unique case (ck_q)
                  CK_ISSUE: ck_q <= CK_WAIT;
                  CK_WAIT: begin
                     if (mem_rvalid) begin
                        if (final_step) begin
                           phase_q   <= PH_DONE;
                           inhibit_q <= 1'b0;
                           ck_q      <= CK_ISSUE;
                        end else if (gap == '0) begin
                           ck_q <= CK_ISSUE;
                        end else begin
                           ck_q    <= CK_GAP;
                           gap_cnt <= gap;
                        end
                     end
                  end
                  default: begin
                     if (gap_cnt <= 1) ck_q <= CK_ISSUE;
                     else gap_cnt <= gap_cnt - 1'b1;
                  end
               endcase
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rtr_checker.sv
module rtr_checker #(
   parameter int AW = 16,
   parameter int EW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    phase,
   input logic          mem_req,
   input logic          mem_we,
   input logic          refresh_inhibit,
   input logic [EW-1:0] err_count,
   input logic          fail_seen,
   input logic [AW-1:0] first_fail_addr,
   input logic          start_req,
   input logic          abort_req
);
   localparam logic [2:0] IDLE = 3'd0, FILL = 3'd1, HOLD = 3'd2, CHECK = 3'd3, DONE = 3'd4;

   p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == IDLE || phase == DONE) |-> !mem_req);

   p_write_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (phase == FILL));

   p_inhibit_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_inhibit |-> (phase == HOLD || phase == CHECK));

   p_count_monotonic_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == CHECK && $past(phase) == CHECK) |-> (err_count >= $past(err_count)));

   p_first_fail_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fail_seen) && phase == CHECK && $past(phase) == CHECK)
         |-> (first_fail_addr == $past(first_fail_addr)));

   p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !abort_req && (phase == HOLD || phase == CHECK)) |=> (phase != FILL));

   p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |=> (phase == IDLE && !refresh_inhibit));
endmodule

bind mem_retention_tester rtr_checker #(.AW(AW), .EW(EW)) u_chk (
   .clk(clk), .rst_n(rst_n), .phase(phase_q), .mem_req(mem_req), .mem_we(mem_we),
   .refresh_inhibit(refresh_inhibit), .err_count(err_count), .fail_seen(fail_seen),
   .first_fail_addr(fail_addr), .start_req(start_p), .abort_req(abort_p)
);

// File: tb/tb_mem_retention_tester.sv
`timescale 1ns/1ps
module tb_mem_retention_tester;
   localparam int AW = 4, DW = 8, EW = 3, HW = 8, GW = 4;
   localparam int NW = 1 << AW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic csr_wr = 1'b0;
   logic [3:0] csr_addr = '0;
   logic [31:0] csr_wdata = '0, csr_rdata;
   logic mem_req, mem_we, mem_rvalid, refresh_inhibit;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;

   always #10 clk = ~clk;

   mem_retention_tester #(.AW(AW), .DW(DW), .EW(EW), .HW(HW), .GW(GW)) dut (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .refresh_inhibit(refresh_inhibit)
   );

   // behavioural memory, one-cycle read latency, with leaky cells
   logic [DW-1:0] mem [NW];
   logic [DW-1:0] decay_mask [NW];
   int decay_req = 0, decay_done = 0;
   int cyc = 0, nwr = 0, nrd = 0, wr_inh = 0, rd_inh = 0;
   int wr_a [1024], wr_d [1024], wr_c [1024], rd_a [1024], rd_c [1024];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_rvalid <= 1'b0;
      if (refresh_inhibit && decay_req != decay_done) begin
         for (int i = 0; i < NW; i++) mem[i] = mem[i] ^ decay_mask[i];
         decay_done <= decay_req;
      end
      if (rst_n && mem_req) begin
         if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_a[nwr % 1024] <= int'(mem_addr);
            wr_d[nwr % 1024] <= int'(mem_wdata);
            wr_c[nwr % 1024] <= cyc;
            if (refresh_inhibit) wr_inh <= wr_inh + 1;
            nwr <= nwr + 1;
         end else begin
            mem_rdata  <= mem[mem_addr];
            mem_rvalid <= 1'b1;
            rd_a[nrd % 1024] <= int'(mem_addr);
            rd_c[nrd % 1024] <= cyc;
            if (refresh_inhibit) rd_inh <= rd_inh + 1;
            nrd <= nrd + 1;
         end
      end
   end

   int checks = 0, fails = 0;
   bit finished = 0;

   task automatic chk(input string req, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   task automatic wr(input logic [3:0] a, input int d);
      @(negedge clk);
      csr_wr = 1'b1; csr_addr = a; csr_wdata = 32'(d);
      @(negedge clk);
      csr_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output int d);
      @(negedge clk);
      csr_addr = a;
      #1 d = int'(csr_rdata);
   endtask

   function automatic int pat(input int mode, input int user, input int addr);
      case (mode)
         0: return 'h55;
         1: return 'hAA;
         2: return user & 'hFF;
         default: return (user ^ addr) & 'hFF;
      endcase
   endfunction

   function automatic int ctrl(input int start, input int inh, input int single, input int mode);
      return start | (inh << 2) | (single << 3) | (mode << 4);
   endfunction

   task automatic wait_done();
      int st;
      for (int k = 0; k < 5000; k++) begin
         rd(4'd8, st);
         if ((st & 7) == 4) return;
      end
      chk("R13 done reached", 0, 1);
   endtask

   int w0, r0;
   task automatic run(input int base, input int last, input int ofs, input int mode,
                      input int user, input int hold, input int gap, input int inh,
                      input int single);
      wr(4'd1, base); wr(4'd2, last); wr(4'd3, ofs); wr(4'd4, user);
      wr(4'd5, hold); wr(4'd6, gap);
      w0 = nwr; r0 = nrd;
      wr(4'd0, ctrl(1, inh, single, mode));
      wait_done();
   endtask

   // checks order, data and timing of the run just finished
   task automatic check_walk(input int base, input int last, input int ofs, input int mode,
                             input int user, input int hold, input int gap, input int single);
      int n, s, ea;
      n = single ? 1 : last + 1;
      s = (ofs > last) ? 0 : ofs;
      chk("R3 write count", nwr - w0, n);
      chk("R4 read count", nrd - r0, n);
      for (int i = 0; i < n; i++) begin
         ea = (base + ((s + i) % (last + 1))) % NW;
         chk("R3 write address", wr_a[(w0 + i) % 1024], ea);
         chk("R2 write data", wr_d[(w0 + i) % 1024], pat(mode, user, ea));
         chk("R4 read address", rd_a[(r0 + i) % 1024], ea);
         if (i > 0) chk("R7 read spacing", rd_c[(r0 + i) % 1024] - rd_c[(r0 + i - 1) % 1024], gap + 2);
      end
      chk("R5 hold length", rd_c[r0 % 1024] - wr_c[(w0 + n - 1) % 1024], hold + 2);
   endtask

   int v, e0, st;
   initial begin
      for (int i = 0; i < NW; i++) begin decay_mask[i] = '0; mem[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(4'd8, v);  chk("R1 phase/flag after reset", v, 0);
      rd(4'd11, v); chk("R1 count after reset", v, 0);
      rd(4'd9, v);  chk("R1 fail address after reset", v, 0);
      chk("R1 mem_req low", int'(mem_req), 0);
      chk("R1 inhibit low", int'(refresh_inhibit), 0);

      // main run with inhibit, offset, hold and gap
      e0 = rd_inh; v = wr_inh;
      run(3, 9, 4, 0, 0, 5, 2, 1, 0);
      check_walk(3, 9, 4, 0, 0, 5, 2, 0);
      chk("R6 no inhibit during fill", wr_inh - v, 0);
      chk("R6 inhibit on every read", rd_inh - e0, 10);
      chk("R6 inhibit released at done", int'(refresh_inhibit), 0);
      rd(4'd11, v); chk("R8 clean run count", v, 0);

      // sweep of offsets (incl. beyond range) and all modes, base wraps address space
      for (int o = 0; o < 12; o++) begin
         run(12, 9, o, o % 4, 'h3C, o % 3, o % 2, 0, 0);
         check_walk(12, 9, o, o % 4, 'h3C, o % 3, o % 2, 0);
         rd(4'd11, v); chk("R8 sweep count", v, 0);
      end

      // leaky cells: one mid-walk, one at the final read (coincides with DONE)
      decay_mask[9] = 8'h01; decay_mask[6] = 8'h80; decay_req++;
      run(3, 9, 4, 2, 'hC3, 4, 1, 1, 0);
      rd(4'd11, v); chk("R8 two mismatches", v, 2);
      rd(4'd9, v);  chk("R9 first fail address", v, 9);
      rd(4'd10, v); chk("R9 first fail data", v, 'hC2);
      rd(4'd8, v);  chk("R13 done with fail flag", v, 12);
      chk("R6 inhibit low after final mismatch", int'(refresh_inhibit), 0);
      for (int i = 0; i < NW; i++) decay_mask[i] = '0;

      // saturation: every word corrupted
      for (int i = 0; i < NW; i++) decay_mask[i] = 8'hFF;
      decay_req++;
      run(3, 9, 0, 1, 0, 2, 0, 1, 0);
      rd(4'd11, v); chk("R8 count saturates", v, 7);
      rd(4'd9, v);  chk("R9 first fail at first read", v, 3);

      // inhibit disabled: leaky cells never decay, restart clears count
      decay_req++;
      e0 = rd_inh;
      run(3, 9, 0, 1, 0, 2, 0, 0, 0);
      rd(4'd11, v); chk("R13 restart clears count", v, 0);
      rd(4'd8, v);  chk("R13 restart clears flag", v, 4);
      chk("R6 inhibit never raised when disabled", rd_inh - e0, 0);
      // inhibited run consumes the pending decay request
      run(3, 9, 0, 1, 0, 0, 0, 1, 0);
      for (int i = 0; i < NW; i++) decay_mask[i] = '0;

      // single-location mode
      run(3, 9, 2, 2, 'h5A, 1, 0, 0, 1);
      check_walk(3, 9, 2, 2, 'h5A, 1, 0, 1);
      rd(4'd11, v); chk("R10 single count", v, 0);

      // start ignored during HOLD, then abort
      wr(4'd5, 200);
      w0 = nwr;
      wr(4'd0, ctrl(1, 1, 0, 0));
      for (int k = 0; k < 40; k++) begin
         rd(4'd8, st);
         if ((st & 7) == 2) break;
      end
      wr(4'd0, ctrl(1, 1, 0, 0));
      rd(4'd8, v); chk("R11 start ignored in hold", v & 7, 2);
      chk("R11 no extra writes", nwr - w0, 10);
      chk("R6 inhibit held in hold", int'(refresh_inhibit), 1);
      r0 = nrd; w0 = nwr;
      wr(4'd0, 2);
      rd(4'd8, v); chk("R12 abort to idle", v & 7, 0);
      chk("R12 inhibit released", int'(refresh_inhibit), 0);
      repeat (250) @(negedge clk);
      chk("R12 no reads after abort", nrd - r0, 0);
      chk("R12 no writes after abort", nwr - w0, 0);
      summary();
   end
endmodule